// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This block computes the rotate, shift, nibble-exchange and single-bit operations of an 8-bit processor datapath. It is purely combinational. The decoder supplies an operation code, the operand, a bit index and the current flag nibble. The block returns the new operand value, a write-back enable and the next flag nibble within the same cycle.

Instruction decode is outside the block. So is the memory read-modify-write sequence that an operand held in memory needs. The caller routes the operand in and writes the result back only when the enable is high.

Operation codes on `op_i` are as follows:

| Code | Operation |
| --- | --- |
| 0 | accumulator rotate left circular |
| 1 | accumulator rotate left through carry |
| 2 | accumulator rotate right circular |
| 3 | accumulator rotate right through carry |
| 4 | rotate left circular |
| 5 | rotate left through carry |
| 6 | rotate right circular |
| 7 | rotate right through carry |
| 8 | arithmetic shift left |
| 9 | arithmetic shift right |
| 10 | logical shift right |
| 11 | nibble swap |
| 12 | bit test |
| 13 | bit set |
| 14 | bit clear |
| 15 | reserved |

The flag nibble is laid out the same way on input and output: bit 3 is zero (Z), bit 2 is subtract (N), bit 1 is half-carry (H) and bit 0 is carry (C).

Top module: `rsb_unit`

## Requirements
- R1: For codes 0 to 3, the result is the rotated operand. Flags Z, N and H are driven to 0, C takes the bit shifted out, and the write-back enable is 1.
- R2: For codes 0, 2, 4 and 6, the bit shifted out also enters the vacated end: bit 0 for left rotates, bit 7 for right rotates.
- R3: For codes 1, 3, 5 and 7, the incoming carry flag (flags_i bit 0) enters the vacated end.
- R4: Code 8 fills bit 0 with 0. Code 9 keeps bit 7 unchanged. Code 10 fills bit 7 with 0.
- R5: For codes 4 to 10, Z is 1 exactly when the 8-bit result is zero, N and H are 0, C takes the bit shifted out, and the write-back enable is 1.
- R6: Code 11 exchanges bits 7:4 with bits 3:0. Z is set from the result, N, H and C are cleared, and the write-back enable is 1.
- R7: Code 12 sets Z to the inverse of operand bit `bit_sel_i`, clears N, sets H and keeps C from flags_i.
- R8: Code 12 drives the write-back enable to 0 and presents the unmodified operand on the result.
- R9: Code 13 forces bit `bit_sel_i` to 1 and code 14 forces it to 0. All other bits are kept, flags_o equals flags_i, and the write-back enable is 1.
- R10: Code 15 drives the write-back enable to 0, passes the operand to the result and returns flags_i unchanged.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| op_i | input | 4 | Operation code |
| operand_i | input | 8 | Value to be operated on |
| bit_sel_i | input | 3 | Bit index for test/set/clear |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| result_o | output | 8 | Operation result |
| wr_en_o | output | 1 | Result must be written back |
| flags_o | output | 4 | Next flags {Z,N,H,C} |

## Verification
The hardest case to reach is a flag that must pass through unchanged, such as C under bit test or all four flags under set/clear. A fixed flag pattern cannot tell "kept" apart from "forced". The stimulus therefore sweeps every operand, every bit index and a flag nibble that changes with each vector. Each kept flag is seen at both 0 and 1, and the rotates through carry see both carry values on every operand.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int OP_W = 4;
  localparam int FLAG_W = 4;
  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ACC_RLC = 4'd0,
    OP_ACC_RL  = 4'd1,
    OP_ACC_RRC = 4'd2,
    OP_ACC_RR  = 4'd3,
    OP_RLC     = 4'd4,
    OP_RL      = 4'd5,
    OP_RRC     = 4'd6,
    OP_RR      = 4'd7,
    OP_SHL_A   = 4'd8,
    OP_SHR_A   = 4'd9,
    OP_SHR_L   = 4'd10,
    OP_SWAP    = 4'd11,
    OP_BTEST   = 4'd12,
    OP_BSET    = 4'd13,
    OP_BCLR    = 4'd14,
    OP_RSVD    = 4'd15
  } rsb_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } rsb_flags_t;

  function automatic logic is_acc_rot(rsb_op_e op);
    return op inside {OP_ACC_RLC, OP_ACC_RL, OP_ACC_RRC, OP_ACC_RR};
  endfunction

  function automatic logic is_gen_shift(rsb_op_e op);
    return op inside {OP_RLC, OP_RL, OP_RRC, OP_RR, OP_SHL_A, OP_SHR_A, OP_SHR_L};
  endfunction
endpackage

// File: rtl/rsb_shift.sv
module rsb_shift
  import rsb_pkg::*;
#(
  parameter int W = 8
) (
  input  rsb_op_e        op,
  input  logic [W-1:0]   a,
  input  logic           cin,
  output logic [W-1:0]   y,
  output logic           cout
);
  logic left;
  logic fill;

  always_comb begin
    left = op inside {OP_ACC_RLC, OP_ACC_RL, OP_RLC, OP_RL, OP_SHL_A};
    cout = left ? a[W-1] : a[0];
    unique case (op)
      OP_ACC_RLC, OP_RLC:                  fill = a[W-1];
      OP_ACC_RRC, OP_RRC:                  fill = a[0];
      OP_ACC_RL, OP_RL, OP_ACC_RR, OP_RR:  fill = cin;
      OP_SHR_A:                            fill = a[W-1];
      default:                             fill = 1'b0;
    endcase
    y = left ? {a[W-2:0], fill} : {fill, a[W-1:1]};
  end
endmodule

// File: rtl/rsb_swap.sv
module rsb_swap #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  localparam int HALF = W / 2;

  generate
    if (W % 2 == 0) begin : g_even
      assign y = {a[HALF-1:0], a[W-1:HALF]};
    end else begin : g_odd
      assign y = {a[HALF-1:0], a[W-1:HALF]};
    end
  endgenerate
endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
  import rsb_pkg::*;
#(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  rsb_op_e          op,
  input  logic [W-1:0]     a,
  input  logic [IDX_W-1:0] idx,
  output logic [W-1:0]     y,
  output logic             sel_bit
);
  logic [W-1:0] mask;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_mask
      assign mask[gi] = (idx == IDX_W'(gi));
    end
  endgenerate

  always_comb begin
    sel_bit = |(a & mask);
    unique case (op)
      OP_BSET: y = a | mask;
      OP_BCLR: y = a & ~mask;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
#(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [W-1:0]      operand_i,
  input  logic [IDX_W-1:0]  bit_sel_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [W-1:0]      result_o,
  output logic              wr_en_o,
  output logic [FLAG_W-1:0] flags_o
);
  rsb_op_e    op;
  rsb_flags_t fin;
  rsb_flags_t fout;
  logic [W-1:0] sh_y, sw_y, bt_y;
  logic         sh_c, bt_bit;

  assign op  = rsb_op_e'(op_i);
  assign fin = rsb_flags_t'(flags_i);

  rsb_shift #(.W(W)) u_shift (
    .op(op), .a(operand_i), .cin(fin.c), .y(sh_y), .cout(sh_c)
  );

  rsb_swap #(.W(W)) u_swap (
    .a(operand_i), .y(sw_y)
  );

  rsb_bitop #(.W(W)) u_bitop (
    .op(op), .a(operand_i), .idx(bit_sel_i), .y(bt_y), .sel_bit(bt_bit)
  );

  always_comb begin
    result_o = operand_i;
    wr_en_o  = 1'b0;
    fout     = fin;
    if (is_acc_rot(op)) begin
      result_o = sh_y;
      wr_en_o  = 1'b1;
      fout     = '{z: 1'b0, n: 1'b0, h: 1'b0, c: sh_c};
    end else if (is_gen_shift(op)) begin
      result_o = sh_y;
      wr_en_o  = 1'b1;
      fout     = '{z: (sh_y == '0), n: 1'b0, h: 1'b0, c: sh_c};
    end else begin
      unique case (op)
        OP_SWAP: begin
          result_o = sw_y;
          wr_en_o  = 1'b1;
          fout     = '{z: (sw_y == '0), n: 1'b0, h: 1'b0, c: 1'b0};
        end
        OP_BTEST: begin
          fout = '{z: ~bt_bit, n: 1'b0, h: 1'b1, c: fin.c};
        end
        OP_BSET, OP_BCLR: begin
          result_o = bt_y;
          wr_en_o  = 1'b1;
        end
        default: ;
      endcase
    end
    flags_o = fout;
  end
endmodule

// File: rtl/rsb_unit_chk.sv
module rsb_unit_chk #(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input logic [3:0]       op_i,
  input logic [W-1:0]     operand_i,
  input logic [IDX_W-1:0] bit_sel_i,
  input logic [3:0]       flags_i,
  input logic [W-1:0]     result_o,
  input logic             wr_en_o,
  input logic [3:0]       flags_o
);
  always_comb begin
    if (op_i <= 4'd3)
      AST_ACC_ROT_FLAGS: assert (flags_o[3:1] == 3'b000 && wr_en_o); // R1
    if (op_i >= 4'd4 && op_i <= 4'd10)
      AST_SHIFT_Z: assert (flags_o[3] == (result_o == '0) && flags_o[2:1] == 2'b00); // R5
    if (op_i == 4'd11)
      AST_SWAP_C_CLEAR: assert (flags_o[0] == 1'b0 && (flags_o[3] == (operand_i == '0))); // R6
    if (op_i == 4'd12)
      AST_BTEST_NO_WRITE: assert (!wr_en_o && result_o == operand_i && flags_o[0] == flags_i[0]); // R8
    if (op_i == 4'd13 || op_i == 4'd14)
      AST_BITMOD_FLAGS: assert (flags_o == flags_i && result_o[bit_sel_i] == (op_i == 4'd13)); // R9
    if (op_i == 4'd15)
      AST_RSVD_INERT: assert (!wr_en_o && flags_o == flags_i && result_o == operand_i); // R10
  end
endmodule

bind rsb_unit rsb_unit_chk #(.W(W)) u_chk (
  .op_i(op_i), .operand_i(operand_i), .bit_sel_i(bit_sel_i), .flags_i(flags_i),
  .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
);

// File: tb/rsb_unit_test.sv
module rsb_unit_test;
  logic       clk;
  logic       rst_n;
  logic [3:0] op_i;
  logic [7:0] operand_i;
  logic [2:0] bit_sel_i;
  logic [3:0] flags_i;
  logic [7:0] result_o;
  logic       wr_en_o;
  logic [3:0] flags_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  rsb_unit uut (
    .op_i(op_i), .operand_i(operand_i), .bit_sel_i(bit_sel_i), .flags_i(flags_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic string tag_of(int op);
    if (op <= 3) return "R1";
    if (op == 4 || op == 6) return "R2";
    if (op == 5 || op == 7) return "R3";
    if (op <= 10) return "R4";
    if (op == 11) return "R6";
    if (op == 12) return "R7";
    if (op <= 14) return "R9";
    return "R10";
  endfunction

  task automatic expect_vec(input int op, input int v, input int b, input int f,
                            output int r, output int we, output int fo);
    int c, outb, z, n, h, cy;
    c  = f % 2;
    r  = v; we = 0; fo = f;
    outb = 0;
    case (op)
      0, 4: begin outb = v / 128; r = (v * 2) % 256 + outb; end // R2
      1, 5: begin outb = v / 128; r = (v * 2) % 256 + c; end    // R3
      2, 6: begin outb = v % 2; r = v / 2 + outb * 128; end
      3, 7: begin outb = v % 2; r = v / 2 + c * 128; end
      8:    begin outb = v / 128; r = (v * 2) % 256; end        // R4
      9:    begin outb = v % 2; r = v / 2 + (v / 128) * 128; end
      10:   begin outb = v % 2; r = v / 2; end
      default: ;
    endcase
    if (op <= 3) begin                    // R1
      we = 1; fo = outb;
    end else if (op <= 10) begin          // R5
      we = 1; fo = (r == 0 ? 8 : 0) + outb;
    end else if (op == 11) begin          // R6
      r = (v % 16) * 16 + v / 16; we = 1; fo = (r == 0) ? 8 : 0;
    end else if (op == 12) begin          // R7 R8
      z = ((v >> b) % 2 == 0) ? 1 : 0;
      n = 0; h = 1; cy = c;
      fo = z * 8 + n * 4 + h * 2 + cy;
    end else if (op == 13) begin          // R9
      r = v | (1 << b); we = 1;
    end else if (op == 14) begin
      r = v & (255 - (1 << b)); we = 1;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int er, ewe, ef;
    rst_n = 1'b0;
    op_i = 4'd15; operand_i = 8'h5A; bit_sel_i = 3'd0; flags_i = 4'hF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    checks++;
    if (result_o !== 8'h5A || wr_en_o !== 1'b0 || flags_o !== 4'hF) begin
      fails++;
      $display("FAIL R10 idle: got r=%h we=%b f=%h exp r=5a we=0 f=f", result_o, wr_en_o, flags_o);
    end
    rst_n = 1'b1;
    for (int op = 0; op < 16; op++) begin
      for (int v = 0; v < 256; v++) begin
        for (int b = 0; b < 8; b++) begin
          int f;
          f = (v * 7 + b * 3 + op) % 16;
          @(negedge clk);
          op_i = op[3:0]; operand_i = v[7:0]; bit_sel_i = b[2:0]; flags_i = f[3:0];
          expect_vec(op, v, b, f, er, ewe, ef);
          #1;
          checks++;
          if (result_o !== er[7:0] || wr_en_o !== ewe[0] || flags_o !== ef[3:0]) begin
            fails++;
            $display("FAIL %s op=%0d v=%h b=%0d fi=%h: got r=%h we=%b f=%h exp r=%h we=%0d f=%h",
                     tag_of(op), op, v, b, f, result_o, wr_en_o, flags_o, er[7:0], ewe, ef[3:0]);
          end
        end
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule